// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the test access port for a memory device. A 16-state controller runs on the test clock and follows the mode-select line. It holds a 3-bit instruction register, a 1-bit bypass path, a 32-bit identification register and a boundary scan chain. The boundary scan chain sits between the device pins and the memory core. Serial data enters on the test data input and leaves on the test data output. The test data output has its own enable and changes only on the falling test-clock edge.

The scan chain has three groups of cells. The cells nearest the test data output capture the input pins. The next cells capture the core's output values. The last cells carry no pin and capture a fixed per-cell default. The active instruction chooses what the output drivers do. In normal operation they follow the core. Under the external-test instruction they drive the chain's update latches with every enable on. Under the high-impedance instruction every enable is off. The core-side inputs always follow the real pins. The interface is the serial test protocol, so no valid/ready handshake applies and no back-pressure exists.

Top module: `jtag_bscan_tap`

## Requirements
- R1: After trst_n is asserted, or whenever the controller is in Test-Logic-Reset, the active instruction is the identification code 001.
- R2: Under code 001, Capture-DR loads the 32-bit ID value, whose bit 0 is forced to 1. Shift-DR then moves the value out least significant bit first.
- R3: Codes 111, 011, 101 and 110 select a 1-bit bypass register. It captures 0 in Capture-DR and delays TDI by one shift.
- R4: Capture-IR loads binary 001 into the instruction shift register, so the first bit shifted out of the IR is 1 and the next two bits are 0.
- R5: Under code 100, Capture-DR loads the chain from the pins. Bits [NUM_IN-1:0] take pin_in and the next NUM_OUT bits take core_out. The chain then shifts least significant bit first.
- R6: The top NUM_SPARE chain bits are tied to no pin. They capture SPARE_DEFAULT on every capture.
- R7: Under code 000, the output drivers use the chain's update latches and every pad_oe bit is 1. The drive starts on the falling TCK edge in Update-IR. Capture-DR still samples the pins, and core_in always equals pin_in.
- R8: Under code 010, every pad_oe bit is 0 and the boundary chain is the path from TDI to TDO.
- R9: tdo_oe is 1 only while the controller is in Shift-IR or Shift-DR. TDO changes only on the falling TCK edge.
- R10: Under any code other than 000 and 010, pad_out equals core_out and pad_oe equals core_oe.
- R11: Five consecutive rising TCK edges with TMS high put the controller in Test-Logic-Reset from any state.
- R12: The output update latches load from the chain on the falling TCK edge in Update-DR when the chain is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Enable for the TDO driver |
| pin_in | input | NUM_IN | Input pin samples |
| core_in | output | NUM_IN | Pin values passed on to the core |
| core_out | input | NUM_OUT | Output values from the core |
| core_oe | input | NUM_OUT | Output enables from the core |
| pad_out | output | NUM_OUT | Values sent to the output drivers |
| pad_oe | output | NUM_OUT | Enables for the output drivers |

## Verification
The chain is captured with distinct pin and core patterns under the sample, external-test and high-impedance codes. A misplaced group boundary, a wrong spare default or a stale capture each shows up as a different bit error. Different preload patterns are then pushed into the update latches under external test, and the drive edge is checked half a clock on either side of Update-IR. The bypass path is tried with all four codes that map onto it. A reset driven by TMS alone is started from Shift-IR and from Pause-DR, and the ID value that follows is read back to show the instruction returned to its default.

// File: rtl/jtag_bscan_pkg.sv
package jtag_bscan_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'd0,
    ST_IDLE    = 4'd1,
    ST_SEL_DR  = 4'd2,
    ST_CAP_DR  = 4'd3,
    ST_SH_DR   = 4'd4,
    ST_EX1_DR  = 4'd5,
    ST_PAU_DR  = 4'd6,
    ST_EX2_DR  = 4'd7,
    ST_UPD_DR  = 4'd8,
    ST_SEL_IR  = 4'd9,
    ST_CAP_IR  = 4'd10,
    ST_SH_IR   = 4'd11,
    ST_EX1_IR  = 4'd12,
    ST_PAU_IR  = 4'd13,
    ST_EX2_IR  = 4'd14,
    ST_UPD_IR  = 4'd15
  } tap_state_e;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_HIZ    = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  function automatic logic op_uses_chain(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_HIZ) || (op == OP_SAMPLE);
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_bscan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_bscan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_tdo
);

  logic [IR_W-1:0] sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sh <= '0;
    else if (state == ST_CAP_IR) sh <= IR_CAPTURE;
    else if (state == ST_SH_IR)  sh <= {tdi, sh[IR_W-1:1]};
  end

  // active instruction changes on the falling edge only
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_q <= OP_IDCODE;
    else if (state == ST_RESET)  ir_q <= OP_IDCODE;
    else if (state == ST_UPD_IR) ir_q <= sh;
  end

  assign ir_tdo = sh[0];

endmodule

// File: rtl/tap_fixed_dr.sv
module tap_fixed_dr
  import jtag_bscan_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [31:0] ID_VALUE = 32'h0A5C_6E03
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_id,
  input  logic       sel_byp,
  output logic       id_tdo,
  output logic       byp_tdo
);

  localparam logic [ID_W-1:0] ID_LOAD = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sh;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sh <= '0;
      byp_q <= 1'b0;
    end else begin
      if (state == ST_CAP_DR) begin
        id_sh <= ID_LOAD;
        byp_q <= 1'b0;
      end else if (state == ST_SH_DR) begin
        if (sel_id)  id_sh <= {tdi, id_sh[ID_W-1:1]};
        if (sel_byp) byp_q <= tdi;
      end
    end
  end

  assign id_tdo  = id_sh[0];
  assign byp_tdo = byp_q;

endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
  import jtag_bscan_pkg::*;
#(
  parameter int                   NUM_IN        = 4,
  parameter int                   NUM_OUT       = 4,
  parameter int                   NUM_SPARE     = 2,
  parameter logic [NUM_SPARE-1:0] SPARE_DEFAULT = 2'b10
) (
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  input  logic               sel,
  input  logic [NUM_IN-1:0]  pin_in,
  input  logic [NUM_OUT-1:0] core_out,
  output logic               bsr_tdo,
  output logic [NUM_OUT-1:0] upd_out
);

  localparam int LEN     = NUM_IN + NUM_OUT + NUM_SPARE;
  localparam int OUT_LO  = NUM_IN;
  localparam int SPR_LO  = NUM_IN + NUM_OUT;

  logic [LEN-1:0] cap_vec;
  logic [LEN-1:0] sh;

  for (genvar g = 0; g < LEN; g++) begin : g_cell
    if (g < OUT_LO) begin : g_in
      assign cap_vec[g] = pin_in[g];
    end else if (g < SPR_LO) begin : g_out
      assign cap_vec[g] = core_out[g-OUT_LO];
    end else begin : g_spare
      assign cap_vec[g] = SPARE_DEFAULT[g-SPR_LO];
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) sh <= '0;
    else if (sel) begin
      if (state == ST_CAP_DR)     sh <= cap_vec;
      else if (state == ST_SH_DR) sh <= {tdi, sh[LEN-1:1]};
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) upd_out <= '0;
    else if (sel && state == ST_UPD_DR) upd_out <= sh[OUT_LO +: NUM_OUT];
  end

  assign bsr_tdo = sh[0];

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
  import jtag_bscan_pkg::*;
#(
  parameter int                   NUM_IN        = 4,
  parameter int                   NUM_OUT       = 4,
  parameter int                   NUM_SPARE     = 2,
  parameter logic [NUM_SPARE-1:0] SPARE_DEFAULT = 2'b10,
  parameter logic [31:0]          ID_VALUE      = 32'h0A5C_6E03
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic [NUM_IN-1:0]  pin_in,
  output logic [NUM_IN-1:0]  core_in,
  input  logic [NUM_OUT-1:0] core_out,
  input  logic [NUM_OUT-1:0] core_oe,
  output logic [NUM_OUT-1:0] pad_out,
  output logic [NUM_OUT-1:0] pad_oe
);

  tap_state_e         state;
  logic [IR_W-1:0]    ir_q;
  logic               ir_tdo, id_tdo, byp_tdo, bsr_tdo;
  logic               sel_bsr, sel_id, sel_byp;
  logic               dr_tdo, tdo_next;
  logic [NUM_OUT-1:0] upd_out;

  tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
  );

  tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .ir_q(ir_q), .ir_tdo(ir_tdo)
  );

  assign sel_bsr = op_uses_chain(ir_q);
  assign sel_id  = (ir_q == OP_IDCODE);
  assign sel_byp = !sel_bsr && !sel_id;

  tap_fixed_dr #(.ID_W(32), .ID_VALUE(ID_VALUE)) u_fix (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
    .sel_id(sel_id), .sel_byp(sel_byp),
    .id_tdo(id_tdo), .byp_tdo(byp_tdo)
  );

  bsr_chain #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT),
    .NUM_SPARE(NUM_SPARE), .SPARE_DEFAULT(SPARE_DEFAULT)
  ) u_bsr (
    .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi), .sel(sel_bsr),
    .pin_in(pin_in), .core_out(core_out),
    .bsr_tdo(bsr_tdo), .upd_out(upd_out)
  );

  always_comb begin
    if (sel_bsr)     dr_tdo = bsr_tdo;
    else if (sel_id) dr_tdo = id_tdo;
    else             dr_tdo = byp_tdo;
    tdo_next = (state == ST_SH_IR) ? ir_tdo : dr_tdo;
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_next;
      tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
    end
  end

  always_comb begin
    case (ir_q)
      OP_EXTEST: begin
        pad_out = upd_out;
        pad_oe  = '1;
      end
      OP_HIZ: begin
        pad_out = core_out;
        pad_oe  = '0;
      end
      default: begin
        pad_out = core_out;
        pad_oe  = core_oe;
      end
    endcase
  end

  assign core_in = pin_in;

endmodule

// File: rtl/jtag_bscan_chk.sv
module jtag_bscan_chk
  import jtag_bscan_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input logic               tck,
  input logic               trst_n,
  input logic               tms,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_q,
  input logic               ir_tdo,
  input logic               byp_tdo,
  input logic [NUM_OUT-1:0] upd_out,
  input logic               tdo_oe,
  input logic [NUM_OUT-1:0] pad_out,
  input logic [NUM_OUT-1:0] pad_oe
);

  logic [2:0] tms_run;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)              tms_run <= '0;
    else if (!tms)            tms_run <= '0;
    else if (tms_run != 3'd5) tms_run <= tms_run + 3'd1;
  end

  assert_reset_idcode_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |-> (ir_q == OP_IDCODE));

  assert_bypass_zero_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && !op_uses_chain(ir_q) && ir_q != OP_IDCODE) |=> (byp_tdo == 1'b0));

  assert_ir_capture_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_tdo == 1'b1));

  assert_extest_drive_R7: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == OP_EXTEST) |-> (pad_out == upd_out && pad_oe == '1));

  assert_hiz_off_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == OP_HIZ) |-> (pad_oe == '0));

  assert_tdo_oe_R9: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

  assert_tms_reset_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (tms_run == 3'd5) |-> (state == ST_RESET));

endmodule

bind jtag_bscan_tap jtag_bscan_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .ir_q(ir_q),
  .ir_tdo(ir_tdo), .byp_tdo(byp_tdo), .upd_out(upd_out), .tdo_oe(tdo_oe),
  .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/sim_jtag_bscan_tap.sv
module sim_jtag_bscan_tap;

  localparam int          NI  = 4;
  localparam int          NO  = 4;
  localparam int          NS  = 2;
  localparam logic [1:0]  SPD = 2'b10;
  localparam logic [31:0] IDV = 32'h0A5C_6E03;
  localparam int          LEN = NI + NO + NS;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic          tdo, tdo_oe;
  logic [NI-1:0] pin_in = 4'b1011;
  logic [NI-1:0] core_in;
  logic [NO-1:0] core_out = 4'b0110;
  logic [NO-1:0] core_oe = 4'b0101;
  logic [NO-1:0] pad_out, pad_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 tck = ~tck;

  jtag_bscan_tap #(
    .NUM_IN(NI), .NUM_OUT(NO), .NUM_SPARE(NS),
    .SPARE_DEFAULT(SPD), .ID_VALUE(IDV)
  ) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .pin_in(pin_in), .core_in(core_in), .core_out(core_out), .core_oe(core_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
    o = tdo;
  endtask

  task automatic scan_dr(input logic [63:0] din, input int n, output logic [63:0] dout);
    logic o;
    dout = '0;
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    dout[0] = o;
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      if (i < n - 1) dout[i+1] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic scan_ir(input logic [2:0] code, output logic [2:0] dout);
    logic o;
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    dout[0] = o;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o);
      if (i < 2) dout[i+1] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic t_reset;
    chk("R9 tdo_oe after reset", 64'(tdo_oe), 64'd0);
    chk("R10 pad_out after reset", 64'(pad_out), 64'(core_out));
    chk("R10 pad_oe after reset", 64'(pad_oe), 64'(core_oe));
    chk("R7 core_in follows pins", 64'(core_in), 64'(pin_in));
  endtask

  task automatic t_idcode;
    logic [63:0] d;
    scan_dr(64'd0, 32, d);
    chk("R1 R2 ID after reset", d, 64'(IDV));
    chk("R2 ID bit0", 64'(d[0]), 64'd1);
  endtask

  task automatic t_ir_capture;
    logic [2:0] c;
    scan_ir(3'b001, c);
    chk("R4 IR capture", 64'(c), 64'b001);
  endtask

  task automatic t_bypass(input logic [2:0] code);
    logic [2:0] c;
    logic [63:0] d;
    logic [7:0] pat;
    pat = 8'hB4 ^ {5'b0, code};
    scan_ir(code, c);
    scan_dr(64'(pat), 9, d);
    chk($sformatf("R3 bypass code %b", code), d[8:0], 64'({pat, 1'b0}));
    chk("R10 pads under bypass", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
  endtask

  task automatic t_sample;
    logic [2:0] c;
    logic [63:0] d;
    pin_in = 4'b1011;
    core_out = 4'b0110;
    scan_ir(3'b100, c);
    scan_dr(64'({2'b01, 4'b1001, 4'b0100}), LEN, d);
    chk("R5 sample capture", d[LEN-1:0], 64'({SPD, core_out, pin_in}));
    chk("R6 spare default", 64'(d[LEN-1 -: NS]), 64'(SPD));
    chk("R10 pads under sample", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
  endtask

  task automatic t_extest;
    logic o;
    logic [63:0] d;
    // IR shift of 000 with the update edge examined in detail
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    tms = 1'b1;
    @(posedge tck);
    #1;
    chk("R7 no drive before Update-IR fall", 64'(pad_oe), 64'(core_oe));
    @(negedge tck);
    #1;
    chk("R7 drive after Update-IR fall", 64'({pad_out, pad_oe}), 64'({4'b1001, 4'b1111}));
    step(1'b0, 1'b0, o);
    pin_in = 4'b0101;
    #1;
    chk("R7 core_in follows pins under extest", 64'(core_in), 64'(pin_in));
    scan_dr(64'({2'b00, 4'b0011, 4'b0000}), LEN, d);
    chk("R7 extest capture", d[LEN-1:0], 64'({SPD, core_out, 4'b0101}));
    chk("R12 update latches reload", 64'(pad_out), 64'(4'b0011));
  endtask

  task automatic t_hiz;
    logic [2:0] c;
    logic [63:0] d;
    scan_ir(3'b010, c);
    chk("R8 all drivers off", 64'(pad_oe), 64'd0);
    scan_dr(64'd0, LEN, d);
    chk("R8 chain selected", d[LEN-1:0], 64'({SPD, core_out, pin_in}));
    scan_ir(3'b100, c);
    chk("R10 pads return to core", 64'({pad_out, pad_oe}), 64'({core_out, core_oe}));
  endtask

  task automatic t_tdo_edge;
    logic [2:0] c;
    logic o;
    scan_ir(3'b111, c);
    chk("R9 tdo_oe idle", 64'(tdo_oe), 64'd0);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk("R9 tdo_oe in shift", 64'(tdo_oe), 64'd1);
    chk("R3 captured zero", 64'(o), 64'd0);
    tms = 1'b0;
    tdi = 1'b1;
    @(posedge tck);
    #1;
    chk("R9 tdo held at rising edge", 64'(tdo), 64'd0);
    @(negedge tck);
    #1;
    chk("R9 tdo moves at falling edge", 64'(tdo), 64'd1);
    step(1'b1, 1'b0, o);
    chk("R9 tdo_oe off in Exit1", 64'(tdo_oe), 64'd0);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
  endtask

  task automatic t_tms_reset;
    logic o;
    logic [2:0] c;
    // from Shift-IR with a bypass code partly shifted
    step(1'b1, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b1, o);
    step(1'b0, 1'b1, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, o);
    step(1'b0, 1'b0, o);
    t_idcode_tag("R11 reset from Shift-IR");
    // from Pause-DR under bypass
    scan_ir(3'b111, c);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    t_idcode_tag("R11 reset from Pause-DR");
  endtask

  task automatic t_idcode_tag(input string tag);
    logic [63:0] d;
    scan_dr(64'd0, 32, d);
    chk(tag, d, 64'(IDV));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic o;
    repeat (3) @(negedge tck);
    #1;
    trst_n = 1'b1;
    step(1'b0, 1'b0, o);
    t_reset();
    t_idcode();
    t_ir_capture();
    t_bypass(3'b111);
    t_bypass(3'b011);
    t_bypass(3'b101);
    t_bypass(3'b110);
    t_sample();
    t_extest();
    t_hiz();
    t_tdo_edge();
    t_tms_reset();
    finish_run();
  end

endmodule